// File: doc/BRIEF.md
# Diagnostic Error Priority Display Controller

This block watches five error sources from a multiplexer/demultiplexer timing system and decides which one the front panel shows. The sources are a mux loss-of-timing error, a demux loss-of-timing error, a demux diagnostic error, a reference-timer error and an out-of-tolerance pulse. Each source is brought through a two-flop synchronizer and a polarity stage, masked by the diagnostic mode, and ranked by a fixed priority. The result drives six registered display enables, a group-select flag and a three-bit card-address code.

A loss of timing anywhere forces the card address to zero. The demux loss-of-timing error is also mirrored to an active-low remote alarm. A three-position mode selector switches off the mux group or the demux group of diagnostics. In the mux-off position it also raises a clear for the channel error counter. The out-of-tolerance input feeds a non-retriggerable pulse stretcher, and that stretcher cannot fire while the associated time counter is being clocked. A lamp-test input lights all six indicators.

Top module: `errPriorityDisplay`

## Requirements
- R1: Errors are active low by default. The ranking from highest to lowest is mux loss-of-timing, demux loss-of-timing, demux diagnostic, reference timer, out-of-tolerance. `dispEn` bits 0..4 show only the winner, in that order: bit0 mux LOT, bit1 demux LOT, bit2 demux diag, bit3 ref timer, bit4 out-of-tolerance. Bit 5 is set whenever any unmasked error is active.
- R2: `groupSel` is 1 only while an unmasked mux loss-of-timing error is active. No other source sets it.
- R3: While either loss-of-timing error is active and unmasked, `cardAddr` is 0. Otherwise `cardAddr` is 3 for demux diagnostic, 4 for reference timer, 5 for out-of-tolerance and 0 when no error is active.
- R4: `remoteLotAlarmN` is 0 exactly while the demux loss-of-timing error is active and unmasked, and 1 otherwise.
- R5: `modeSel` has four codes. 2'b00 is normal, with all sources enabled. 2'b01 is mux off, which masks mux LOT, reference timer and out-of-tolerance. 2'b10 is demux off, which masks demux LOT and demux diagnostic. 2'b11 acts as normal.
- R6: `cntClear` is 1 while mux-off mode is selected and 0 otherwise.
- R7: While `lampTestN` is 0, all six `dispEn` bits are 1, whatever the error state.
- R8: A falling edge on `ootPulseN` fires a one-shot that reports out-of-tolerance for exactly OOT_WIDTH cycles (default 8). Further edges during that window do not extend it.
- R9: A falling edge on `ootPulseN` is ignored while `ootCntClk` is 1. Out-of-tolerance is also ignored in mux-off mode.
- R10: A level change on any error, mode or lamp input reaches the outputs on the third rising clock edge. An out-of-tolerance pulse reaches them on the fourth.
- R11: While `rstN` is 0, the outputs are `dispEn`=0, `groupSel`=0, `cardAddr`=0, `cntClear`=0 and `remoteLotAlarmN`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| muxLotN | input | 1 | Mux loss-of-timing error |
| demuxLotN | input | 1 | Demux loss-of-timing error |
| demuxDiagN | input | 1 | Demux diagnostic error |
| refTimerN | input | 1 | Reference-timer error |
| ootPulseN | input | 1 | Out-of-tolerance transition pulse |
| ootCntClk | input | 1 | High while the tolerance time counter is clocked |
| lampTestN | input | 1 | Lamp test, active low |
| modeSel | input | 2 | Diagnostic mode selector |
| dispEn | output | 6 | Front-panel indicator enables |
| groupSel | output | 1 | Highest-group flag (mux loss of timing) |
| cardAddr | output | 3 | Card-address code of the winning error |
| remoteLotAlarmN | output | 1 | Remote demux loss-of-timing alarm, active low |
| cntClear | output | 1 | Clear for the channel error counter |

## Verification
Level inputs pass through two synchronizer flops and one output register, so their results are due after the third rising edge. The out-of-tolerance path adds the one-shot counter register, so it is due after the fourth. The bench changes inputs on a falling edge, waits exactly that many rising edges, and samples on the next falling edge. For the one-shot it samples the first and last cycles of the stretched window and the cycle just after it, which pins the width to OOT_WIDTH.

// File: rtl/errdisp_pkg.sv
package errdisp_pkg;
  localparam int NUM_SRC = 5;
  localparam int IDX_MUX_LOT = 0;
  localparam int IDX_DMX_LOT = 1;
  localparam int IDX_DMX_DIAG = 2;
  localparam int IDX_REF_TMR = 3;
  localparam int IDX_OOT = 4;

  localparam logic [2:0] ADDR_NONE = 3'd0;
  localparam logic [2:0] ADDR_DMX_DIAG = 3'd3;
  localparam logic [2:0] ADDR_REF_TMR = 3'd4;
  localparam logic [2:0] ADDR_OOT = 3'd5;

  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_MUX_OFF = 2'b01,
    MODE_DEMUX_OFF = 2'b10,
    MODE_NORM_ALT = 2'b11
  } diagMode_e;

  typedef struct packed {
    logic muxEnable;
    logic demuxEnable;
    logic lampTest;
    logic ootActive;
    logic cntClear;
  } ctrlStrobe_t;
endpackage

// File: rtl/errdisp_sync.sv
module errdisp_sync #(
  parameter int WIDTH = 9,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      dOut <= RST_VAL;
    end else begin
      stage1 <= dIn;
      dOut <= stage1;
    end
  end
endmodule

// File: rtl/errdisp_ctrl.sv
module errdisp_ctrl
  import errdisp_pkg::*;
#(
  parameter int OOT_WIDTH = 8,
  parameter bit OOT_ACTIVE_HIGH = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSync,
  input  logic        lampSyncN,
  input  logic        ootSync,
  input  logic        cntClkSync,
  output ctrlStrobe_t strb
);
  localparam int CNT_W = $clog2(OOT_WIDTH + 1);

  diagMode_e mode;
  logic muxEnable, demuxEnable;
  logic ootLevel, ootPrev, ootTrigger;
  logic [CNT_W-1:0] ootCnt;

  assign mode = diagMode_e'(modeSync);
  assign muxEnable = (mode != MODE_MUX_OFF);
  assign demuxEnable = (mode != MODE_DEMUX_OFF);
  assign ootLevel = ootSync ^ ~OOT_ACTIVE_HIGH;
  assign ootTrigger = ootLevel && !ootPrev && !cntClkSync && muxEnable && (ootCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ootPrev <= 1'b0;
      ootCnt <= '0;
    end else begin
      ootPrev <= ootLevel;
      if (!muxEnable) ootCnt <= '0;
      else if (ootTrigger) ootCnt <= CNT_W'(OOT_WIDTH);
      else if (ootCnt != '0) ootCnt <= ootCnt - 1'b1;
    end
  end

  always_comb begin
    strb.muxEnable = muxEnable;
    strb.demuxEnable = demuxEnable;
    strb.lampTest = ~lampSyncN;
    strb.ootActive = (ootCnt != '0);
    strb.cntClear = !muxEnable;
  end

  AST_OOT_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    (cntClkSync && ootCnt == '0) |=> (ootCnt == '0)); // R9
  AST_OOT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    (ootCnt != '0 && muxEnable) |=> (ootCnt == CNT_W'($past(ootCnt) - 1'b1))); // R8
endmodule

// File: rtl/errdisp_dp.sv
module errdisp_dp
  import errdisp_pkg::*;
#(
  parameter logic [3:0] LVL_ACTIVE_HIGH = 4'b0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  errSync,
  input  ctrlStrobe_t strb,
  output logic [5:0]  dispEn,
  output logic        groupSel,
  output logic [2:0]  cardAddr,
  output logic        remoteLotAlarmN,
  output logic        cntClear
);
  logic [NUM_SRC-1:0] errAct, errMasked, winner;
  logic lotPresent;
  logic [2:0] addrNext;
  logic [5:0] dispNext;

  for (genvar i = 0; i < 4; i++) begin : g_pol
    assign errAct[i] = errSync[i] ^ ~LVL_ACTIVE_HIGH[i];
  end
  assign errAct[IDX_OOT] = strb.ootActive;

  always_comb begin
    errMasked = errAct;
    errMasked[IDX_MUX_LOT] = errAct[IDX_MUX_LOT] & strb.muxEnable;
    errMasked[IDX_REF_TMR] = errAct[IDX_REF_TMR] & strb.muxEnable;
    errMasked[IDX_OOT] = errAct[IDX_OOT] & strb.muxEnable;
    errMasked[IDX_DMX_LOT] = errAct[IDX_DMX_LOT] & strb.demuxEnable;
    errMasked[IDX_DMX_DIAG] = errAct[IDX_DMX_DIAG] & strb.demuxEnable;
  end

  always_comb begin
    winner = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (errMasked[i]) winner = NUM_SRC'(1) << i;
    end
  end

  assign lotPresent = errMasked[IDX_MUX_LOT] | errMasked[IDX_DMX_LOT];

  always_comb begin
    addrNext = ADDR_NONE;
    if (!lotPresent) begin
      if (winner[IDX_DMX_DIAG]) addrNext = ADDR_DMX_DIAG;
      else if (winner[IDX_REF_TMR]) addrNext = ADDR_REF_TMR;
      else if (winner[IDX_OOT]) addrNext = ADDR_OOT;
    end
    dispNext = strb.lampTest ? '1 : {|errMasked, winner};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispEn <= '0;
      groupSel <= 1'b0;
      cardAddr <= ADDR_NONE;
      remoteLotAlarmN <= 1'b1;
      cntClear <= 1'b0;
    end else begin
      dispEn <= dispNext;
      groupSel <= errMasked[IDX_MUX_LOT];
      cardAddr <= addrNext;
      remoteLotAlarmN <= ~errMasked[IDX_DMX_LOT];
      cntClear <= strb.cntClear;
    end
  end

  AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (!rstN)
    strb.lampTest |=> (dispEn == 6'h3f)); // R7
  AST_LOT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (groupSel || !remoteLotAlarmN) |-> (cardAddr == 3'd0)); // R3
  AST_WINNER_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.lampTest) |-> $onehot0(dispEn[4:0])); // R1
  AST_MUXOFF_NO_GS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.muxEnable |=> !groupSel); // R2
  AST_ALARM_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !strb.demuxEnable |=> remoteLotAlarmN); // R4
  AST_CLEAR_MUXOFF: assert property (@(posedge clk) disable iff (!rstN)
    !strb.muxEnable |=> cntClear); // R6
endmodule

// File: rtl/errPriorityDisplay.sv
module errPriorityDisplay
  import errdisp_pkg::*;
#(
  parameter int OOT_WIDTH = 8,
  parameter logic [4:0] ERR_ACTIVE_HIGH = 5'b00000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       muxLotN,
  input  logic       demuxLotN,
  input  logic       demuxDiagN,
  input  logic       refTimerN,
  input  logic       ootPulseN,
  input  logic       ootCntClk,
  input  logic       lampTestN,
  input  logic [1:0] modeSel,
  output logic [5:0] dispEn,
  output logic       groupSel,
  output logic [2:0] cardAddr,
  output logic       remoteLotAlarmN,
  output logic       cntClear
);
  localparam int SYNC_W = 9;
  localparam logic [SYNC_W-1:0] SYNC_RST = {2'b00, 1'b1, 1'b0, ~ERR_ACTIVE_HIGH};

  logic [SYNC_W-1:0] rawVec, syncVec;
  ctrlStrobe_t strb;

  assign rawVec = {modeSel, lampTestN, ootCntClk, ootPulseN, refTimerN, demuxDiagN, demuxLotN, muxLotN};

  errdisp_sync #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rstN(rstN), .dIn(rawVec), .dOut(syncVec)
  );

  errdisp_ctrl #(.OOT_WIDTH(OOT_WIDTH), .OOT_ACTIVE_HIGH(ERR_ACTIVE_HIGH[IDX_OOT])) ctrl_i (
    .clk(clk), .rstN(rstN), .modeSync(syncVec[8:7]), .lampSyncN(syncVec[6]),
    .ootSync(syncVec[4]), .cntClkSync(syncVec[5]), .strb(strb)
  );

  errdisp_dp #(.LVL_ACTIVE_HIGH(ERR_ACTIVE_HIGH[3:0])) dp_i (
    .clk(clk), .rstN(rstN), .errSync(syncVec[3:0]), .strb(strb),
    .dispEn(dispEn), .groupSel(groupSel), .cardAddr(cardAddr),
    .remoteLotAlarmN(remoteLotAlarmN), .cntClear(cntClear)
  );
endmodule

// File: tb/errPriorityDisplay_tb.sv
module errPriorityDisplay_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic muxLotN = 1, demuxLotN = 1, demuxDiagN = 1, refTimerN = 1;
  logic ootPulseN = 1, ootCntClk = 0, lampTestN = 1;
  logic [1:0] modeSel = 2'b00;
  logic [5:0] dispEn;
  logic groupSel, remoteLotAlarmN, cntClear;
  logic [2:0] cardAddr;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  errPriorityDisplay #(.OOT_WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .muxLotN(muxLotN), .demuxLotN(demuxLotN),
    .demuxDiagN(demuxDiagN), .refTimerN(refTimerN), .ootPulseN(ootPulseN),
    .ootCntClk(ootCntClk), .lampTestN(lampTestN), .modeSel(modeSel),
    .dispEn(dispEn), .groupSel(groupSel), .cardAddr(cardAddr),
    .remoteLotAlarmN(remoteLotAlarmN), .cntClear(cntClear)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitEdges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setErr(logic m, logic dl, logic dd, logic rt);
    muxLotN = m; demuxLotN = dl; demuxDiagN = dd; refTimerN = rt;
  endtask

  task automatic checkOut(string req, logic [5:0] eDisp, logic eGs, logic [2:0] eAddr, logic eAlm, logic eClr);
    check({req, " dispEn"}, 32'(dispEn), 32'(eDisp));
    check({req, " groupSel"}, 32'(groupSel), 32'(eGs));
    check({req, " cardAddr"}, 32'(cardAddr), 32'(eAddr));
    check({req, " alarm"}, 32'(remoteLotAlarmN), 32'(eAlm));
    check({req, " cntClear"}, 32'(cntClear), 32'(eClr));
  endtask

  task automatic idle();
    setErr(1, 1, 1, 1); ootPulseN = 1; ootCntClk = 0; lampTestN = 1; modeSel = 2'b00;
    waitEdges(W + 6);
  endtask

  task automatic testReset();
    waitEdges(2);
    checkOut("R11 reset", 6'h00, 0, 3'd0, 1, 0);
    rstN = 1'b1;
    waitEdges(4);
    checkOut("R11 after reset", 6'h00, 0, 3'd0, 1, 0);
  endtask

  task automatic testSingles();
    setErr(0, 1, 1, 1); waitEdges(2);
    check("R10 not yet at edge 2", 32'(groupSel), 32'd0);
    waitEdges(0);
    @(posedge clk); @(negedge clk);
    checkOut("R2 mux LOT", 6'h21, 1, 3'd0, 1, 0);
    setErr(1, 0, 1, 1); waitEdges(3);
    checkOut("R4 demux LOT", 6'h22, 0, 3'd0, 0, 0);
    setErr(1, 1, 0, 1); waitEdges(3);
    checkOut("R3 demux diag", 6'h24, 0, 3'd3, 1, 0);
    setErr(1, 1, 1, 0); waitEdges(3);
    checkOut("R3 ref timer", 6'h28, 0, 3'd4, 1, 0);
    idle();
  endtask

  task automatic testPriority();
    setErr(0, 0, 0, 0); waitEdges(3);
    checkOut("R1 all active", 6'h21, 1, 3'd0, 0, 0);
    setErr(1, 1, 0, 0); waitEdges(3);
    checkOut("R1 diag over timer", 6'h24, 0, 3'd3, 1, 0);
    setErr(1, 0, 0, 0); waitEdges(3);
    checkOut("R3 demux LOT zero addr", 6'h22, 0, 3'd0, 0, 0);
    modeSel = 2'b11; setErr(0, 1, 0, 1); waitEdges(3);
    checkOut("R5 mode 11 normal", 6'h21, 1, 3'd0, 1, 0);
    idle();
  endtask

  task automatic testModes();
    modeSel = 2'b01; setErr(0, 0, 0, 0); waitEdges(3);
    checkOut("R5 R6 mux off", 6'h22, 0, 3'd0, 0, 1);
    setErr(0, 1, 1, 0); waitEdges(3);
    checkOut("R5 mux off masks mux group", 6'h00, 0, 3'd0, 1, 1);
    modeSel = 2'b10; setErr(1, 0, 0, 0); waitEdges(3);
    checkOut("R4 R5 demux off", 6'h28, 0, 3'd4, 1, 0);
    idle();
  endtask

  task automatic testLamp();
    lampTestN = 0; waitEdges(3);
    checkOut("R7 lamp idle", 6'h3f, 0, 3'd0, 1, 0);
    setErr(1, 1, 0, 1); waitEdges(3);
    checkOut("R7 lamp with error", 6'h3f, 0, 3'd3, 1, 0);
    idle();
  endtask

  task automatic testOot();
    ootPulseN = 0; waitEdges(2);
    ootPulseN = 1; waitEdges(2);
    checkOut("R8 R10 oot first", 6'h30, 0, 3'd5, 1, 0);
    ootPulseN = 0; waitEdges(1);
    ootPulseN = 1; waitEdges(W - 2);
    checkOut("R8 oot last", 6'h30, 0, 3'd5, 1, 0);
    waitEdges(1);
    checkOut("R8 oot ended", 6'h00, 0, 3'd0, 1, 0);
    idle();
    ootCntClk = 1; waitEdges(3);
    ootPulseN = 0; waitEdges(2);
    ootPulseN = 1; waitEdges(2);
    checkOut("R9 inhibited by counter clock", 6'h00, 0, 3'd0, 1, 0);
    idle();
    modeSel = 2'b01; waitEdges(3);
    ootPulseN = 0; waitEdges(2);
    ootPulseN = 1; waitEdges(2);
    checkOut("R9 oot masked mux off", 6'h00, 0, 3'd0, 1, 1);
    idle();
  endtask

  initial begin
    testReset();
    testSingles();
    testPriority();
    testModes();
    testLamp();
    testOot();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule